// File: doc/BRIEF.md
# Disk Read DMA Channel

This block moves 16-bit words arriving from the disk data path into main memory. Software loads a word-granular address pointer, a transfer length and a small control register through a simple register-write port. The channel then waits for the bus scheduler to grant it a disk slot. On each granted slot it stores one word, provided that the channel is enabled and set to read direction, the shared system DMA control word has both its disk bit and its master bit set, and words remain to be moved. After storing the word it steps the pointer forward by one and counts the length down by one.

The memory address is the pointer ANDed with a mask derived from the power-of-two memory size, so a pointer that runs past the end of memory wraps to the start. When the last word of a block is stored, the channel raises a one-cycle block-done request toward the shared interrupt controller. Writing a new length at any time restarts the count from that value. Until a data separator exists, the stored word comes straight from an input data port.

Top module: `disk_rd_dma`

## Requirements
- R1: After reset, `mem_we` and `irq_blk` are 0. The pointer, the length, the enable bit and the direction bit are all 0, so a granted slot right after reset stores nothing.
- R2: When control bit 0 (enable) is 0, a granted slot stores nothing and leaves the pointer and the length unchanged.
- R3: When control bit 1 (direction, 1 = write to disk) is 1, a granted slot stores nothing and leaves the pointer and the length unchanged.
- R4: A slot transfers only when bit 4 (disk) and bit 9 (master) of `dma_ctrl` are both 1. If either bit is 0, nothing is stored.
- R5: Without `slot_grant`, no word is stored.
- R6: A qualifying grant in cycle n gives `mem_we`=1 in cycle n+1. In that cycle `mem_wdata` equals the `din` sampled in cycle n and `mem_addr` equals the pointer ANDed with (RAM_WORDS-1).
- R7: Each transfer increments the pointer by one, so successive transfers write successive addresses.
- R8: When the length is 0, a granted slot stores nothing.
- R9: The transfer that takes the length from 1 to 0 raises `irq_blk` for exactly one cycle, in the same cycle as its `mem_we`. No other transfer raises it.
- R10: Addresses wrap. A pointer of RAM_WORDS addresses word 0.
- R11: Register writes use `reg_sel` 0 for pointer bits 15:0, 1 for the pointer's upper bits, 2 for the length and 3 for control. A length write restarts the count. If it lands in the same cycle as a transfer, the word is still stored and the pointer still advances, the written length replaces the count, and no block-done request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 length, 3 control |
| reg_wdata | input | 16 | Register write data |
| dma_ctrl | input | 16 | Shared system DMA control word (bit 4 disk, bit 9 master) |
| slot_grant | input | 1 | Disk slot granted this cycle |
| din | input | 16 | Disk data word to store |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W (19) | Masked word address |
| mem_wdata | output | 16 | Word to write |
| irq_blk | output | 1 | One-cycle block-done interrupt request |

## Verification
The bench exercises each gating condition on its own: channel disabled, write direction, each of the two shared DMA bits missing, and no grant. After each one it re-enables the channel and confirms that the next stored address and the block-done timing are unchanged. A design that stepped the pointer or length on a gated slot would show a shifted address or an early interrupt. The bench runs the pointer across the top of memory to catch a missing mask, and drains a block to zero and grants again to catch an interrupt that repeats or a counter that wraps. It reloads the length both between transfers and in the same cycle as a transfer. Each of these reloads catches an interrupt raised from the stale count, or a reload that the decrement overrides.

// File: rtl/dskdma_pkg.sv
package dskdma_pkg;
    localparam int WORD_W = 16;

    localparam logic [1:0] SEL_PTR_LO = 2'd0;
    localparam logic [1:0] SEL_PTR_HI = 2'd1;
    localparam logic [1:0] SEL_LEN    = 2'd2;
    localparam logic [1:0] SEL_CTL    = 2'd3;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_DIR_BIT = 1;

    localparam int SYS_DISK_BIT   = 4;
    localparam int SYS_MASTER_BIT = 9;
    localparam logic [WORD_W-1:0] SYS_NEED =
        (WORD_W'(1) << SYS_DISK_BIT) | (WORD_W'(1) << SYS_MASTER_BIT);
endpackage

// File: rtl/dskdma_gate.sv
module dskdma_gate
    import dskdma_pkg::*;
(
    input  logic              slot_grant_i,
    input  logic [WORD_W-1:0] sys_ctrl_i,
    input  logic              en_i,
    input  logic              dir_wr_i,
    input  logic              len_nz_i,
    output logic              go_o
);
    logic sys_ok;

    always_comb begin
        sys_ok = ((sys_ctrl_i & SYS_NEED) == SYS_NEED);
        go_o   = slot_grant_i && sys_ok && en_i && !dir_wr_i && len_nz_i;
    end
endmodule

// File: rtl/dskdma_regs.sv
module dskdma_regs
    import dskdma_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        sel_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              go_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              len_nz_o,
    output logic              en_o,
    output logic              dir_wr_o,
    output logic              last_o
);
    localparam int HI_W = ADDR_W - 16;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [LEN_W-1:0]  len;
        logic              en;
        logic              dir_wr;
    } chan_t;

    chan_t st_d, st_q;
    logic  len_wr;

    always_comb begin
        st_d   = st_q;
        len_wr = we_i && (sel_i == SEL_LEN);
        if (go_i) begin
            st_d.ptr = st_q.ptr + ADDR_W'(1);
            st_d.len = st_q.len - LEN_W'(1);
        end
        if (we_i) begin
            case (sel_i)
                SEL_PTR_LO: st_d.ptr = {st_q.ptr[ADDR_W-1:16], wdata_i};
                SEL_PTR_HI: st_d.ptr = {wdata_i[HI_W-1:0], st_q.ptr[15:0]};
                SEL_LEN:    st_d.len = wdata_i[LEN_W-1:0];
                default: begin
                    st_d.en     = wdata_i[CTL_EN_BIT];
                    st_d.dir_wr = wdata_i[CTL_DIR_BIT];
                end
            endcase
        end
        last_o   = go_i && (st_q.len == LEN_W'(1)) && !len_wr;
        ptr_o    = st_q.ptr;
        len_nz_o = (st_q.len != '0);
        en_o     = st_q.en;
        dir_wr_o = st_q.dir_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a length write always lands, whatever the transfer did
    assert_len_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_LEN) |=> (len_nz_o == ($past(wdata_i[LEN_W-1:0]) != '0)));
endmodule

// File: rtl/dskdma_port.sv
module dskdma_port
    import dskdma_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int RAM_WORDS = 262144
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              last_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [WORD_W-1:0] din_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] RAM_MASK = ADDR_W'(RAM_WORDS - 1);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic              irq;
    } wport_t;

    wport_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.we    = go_i;
        p_d.irq   = last_i;
        if (go_i) begin
            p_d.addr  = ptr_i & RAM_MASK;
            p_d.wdata = din_i;
        end
        we_o    = p_q.we;
        addr_o  = p_q.addr;
        wdata_o = p_q.wdata;
        irq_o   = p_q.irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R10: no address outside the memory
    assert_addr_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> ((addr_o & ~RAM_MASK) == '0));
    // R9: block-done only together with a stored word
    assert_irq_with_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> we_o);
endmodule

// File: rtl/disk_rd_dma.sv
module disk_rd_dma
    import dskdma_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int LEN_W     = 16,
    parameter int RAM_WORDS = 262144
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [15:0]       reg_wdata,
    input  logic [15:0]       dma_ctrl,
    input  logic              slot_grant,
    input  logic [15:0]       din,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              irq_blk
);
    logic              go;
    logic              last;
    logic [ADDR_W-1:0] ptr;
    logic              len_nz;
    logic              en;
    logic              dir_wr;

    dskdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we),
        .sel_i    (reg_sel),
        .wdata_i  (reg_wdata),
        .go_i     (go),
        .ptr_o    (ptr),
        .len_nz_o (len_nz),
        .en_o     (en),
        .dir_wr_o (dir_wr),
        .last_o   (last)
    );

    dskdma_gate u_gate (
        .slot_grant_i (slot_grant),
        .sys_ctrl_i   (dma_ctrl),
        .en_i         (en),
        .dir_wr_i     (dir_wr),
        .len_nz_i     (len_nz),
        .go_o         (go)
    );

    dskdma_port #(.ADDR_W(ADDR_W), .RAM_WORDS(RAM_WORDS)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .last_i  (last),
        .ptr_i   (ptr),
        .din_i   (din),
        .we_o    (mem_we),
        .addr_o  (mem_addr),
        .wdata_o (mem_wdata),
        .irq_o   (irq_blk)
    );

    assert_no_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_grant |=> !mem_we);
    assert_sys_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_ctrl[SYS_DISK_BIT] && dma_ctrl[SYS_MASTER_BIT]) |=> !mem_we);
    assert_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mem_we);
    assert_dir_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> !mem_we);
    assert_len_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !len_nz |=> !mem_we);
    assert_data_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_grant && en && !dir_wr && len_nz &&
        dma_ctrl[SYS_DISK_BIT] && dma_ctrl[SYS_MASTER_BIT]
        |=> mem_we && (mem_wdata == $past(din)));
endmodule

// File: tb/sim_disk_rd_dma.sv
`timescale 1ns/1ps
module sim_disk_rd_dma;
    localparam int ADDR_W = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [15:0]       reg_wdata = 16'h0;
    logic [15:0]       dma_ctrl = 16'h0;
    logic              slot_grant = 1'b0;
    logic [15:0]       din = 16'hFFFF;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_wdata;
    logic              irq_blk;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    disk_rd_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dma_ctrl(dma_ctrl), .slot_grant(slot_grant),
        .din(din), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .irq_blk(irq_blk)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic setp(input logic [ADDR_W-1:0] a);
        wr(2'd0, a[15:0]);
        wr(2'd1, 16'(a[ADDR_W-1:16]));
    endtask

    task automatic pulse(input logic [15:0] d);
        slot_grant = 1'b1; din = d;
        @(negedge clk);
        slot_grant = 1'b0;
    endtask

    task automatic expect_word(input string tag, input logic [ADDR_W-1:0] a,
                               input logic [15:0] d, input logic irq);
        chk({tag, " we"}, 32'(mem_we), 32'd1);
        chk({tag, " addr"}, 32'(mem_addr), 32'(a));
        chk({tag, " data"}, 32'(mem_wdata), 32'(d));
        chk({tag, " irq"}, 32'(irq_blk), 32'(irq));
    endtask

    task automatic t_reset;
        chk("R1 we after reset", 32'(mem_we), 32'd0);
        chk("R1 irq after reset", 32'(irq_blk), 32'd0);
        dma_ctrl = 16'h0210;
        pulse(16'h1234);
        chk("R1 grant after reset stores nothing", 32'(mem_we), 32'd0);
    endtask

    task automatic t_basic;
        setp(19'h01000); wr(2'd2, 16'd3); wr(2'd3, 16'h0001);
        pulse(16'hA001); expect_word("R6 first", 19'h01000, 16'hA001, 1'b0);
        pulse(16'h5A5A); expect_word("R7 second", 19'h01001, 16'h5A5A, 1'b0);
        pulse(16'hFFFF); expect_word("R9 last", 19'h01002, 16'hFFFF, 1'b1);
        @(negedge clk);
        chk("R9 irq one cycle", 32'(irq_blk), 32'd0);
        pulse(16'h0BAD);
        chk("R8 zero length stores nothing", 32'(mem_we), 32'd0);
        chk("R9 no repeat irq", 32'(irq_blk), 32'd0);
    endtask

    task automatic t_disabled;
        setp(19'h02000); wr(2'd2, 16'd2); wr(2'd3, 16'h0000);
        pulse(16'h1111);
        chk("R2 disabled no write", 32'(mem_we), 32'd0);
        wr(2'd3, 16'h0001);
        pulse(16'h2222); expect_word("R2 pointer kept", 19'h02000, 16'h2222, 1'b0);
        pulse(16'h3333); expect_word("R2 length kept", 19'h02001, 16'h3333, 1'b1);
    endtask

    task automatic t_dir;
        setp(19'h03000); wr(2'd2, 16'd1); wr(2'd3, 16'h0003);
        pulse(16'h4444);
        chk("R3 write direction no store", 32'(mem_we), 32'd0);
        wr(2'd3, 16'h0001);
        pulse(16'h5555); expect_word("R3 state kept", 19'h03000, 16'h5555, 1'b1);
    endtask

    task automatic t_master;
        setp(19'h04000); wr(2'd2, 16'd1); wr(2'd3, 16'h0001);
        dma_ctrl = 16'h0010; pulse(16'h6666);
        chk("R4 master bit clear", 32'(mem_we), 32'd0);
        dma_ctrl = 16'h0200; pulse(16'h6666);
        chk("R4 disk bit clear", 32'(mem_we), 32'd0);
        dma_ctrl = 16'hFDEF; pulse(16'h6666);
        chk("R4 other bits set only", 32'(mem_we), 32'd0);
        dma_ctrl = 16'h0210; pulse(16'h7777);
        expect_word("R4 both set", 19'h04000, 16'h7777, 1'b1);
    endtask

    task automatic t_nogrant;
        setp(19'h05000); wr(2'd2, 16'd1); wr(2'd3, 16'h0001);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R5 idle without grant", 32'(mem_we), 32'd0);
        end
        pulse(16'h8888); expect_word("R5 then grant", 19'h05000, 16'h8888, 1'b1);
    endtask

    task automatic t_wrap;
        setp(19'h3FFFE); wr(2'd2, 16'd3); wr(2'd3, 16'h0001);
        pulse(16'h0001); expect_word("R10 below top", 19'h3FFFE, 16'h0001, 1'b0);
        pulse(16'h0002); expect_word("R10 top", 19'h3FFFF, 16'h0002, 1'b0);
        pulse(16'h0003); expect_word("R10 wrapped", 19'h00000, 16'h0003, 1'b1);
    endtask

    task automatic t_reload;
        setp(19'h06000); wr(2'd2, 16'd3); wr(2'd3, 16'h0001);
        pulse(16'hC000); expect_word("R11 before reload", 19'h06000, 16'hC000, 1'b0);
        wr(2'd2, 16'd2);
        pulse(16'hC001); expect_word("R11 after reload", 19'h06001, 16'hC001, 1'b0);
        pulse(16'hC002); expect_word("R11 end of reload", 19'h06002, 16'hC002, 1'b1);
        setp(19'h06100); wr(2'd2, 16'd1);
        slot_grant = 1'b1; din = 16'hD000;
        reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 16'd2;
        @(negedge clk);
        slot_grant = 1'b0; reg_we = 1'b0;
        expect_word("R11 same-cycle reload", 19'h06100, 16'hD000, 1'b0);
        pulse(16'hD001); expect_word("R11 count restarted", 19'h06101, 16'hD001, 1'b0);
        pulse(16'hD002); expect_word("R11 restarted end", 19'h06102, 16'hD002, 1'b1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_disabled();
        t_dir();
        t_master();
        t_nogrant();
        t_wrap();
        t_reload();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule